// File: doc/BRIEF.md
# Serial-Load Latched Output Driver

This block is the digital core of a multi-channel display column driver. A serial bit stream is clocked into an N-stage shift register on every rising clock edge, while a latch stage, controlled by a load-enable input, decides when the shifted pattern reaches the parallel outputs. As long as load-enable is high the latch follows the shift register; once it drops, the outputs keep the last loaded pattern while new data shifts in behind them.

Two output-control inputs condition every latched bit on its way to the pins: the outputs can be forced all high, forced all low, inverted, or passed straight through. A serial output always shows the last shift stage, so several blocks can be chained into one long register. A build parameter reverses the order in which shift stages reach the output channels. This lets a board route the chain in either direction around a panel edge.

The latch is modelled as a register in the shift-clock domain plus a bypass path. While load-enable is high, the view seen by the outputs is the live shift-register contents. While it is low, the view is the captured copy.

Top module: `serial_latched_driver`

## Requirements
- R1: On each rising clock edge with `rst_n` high, `sdi` enters shift stage 1 and every stage k (1 <= k < N) passes its value to stage k+1.
- R2: `sdo` always equals shift stage N, so a bit applied on `sdi` before an edge first appears on `sdo` after exactly N rising edges, counting that edge.
- R3: While `load_en` is high, the latched view equals the current shift-register contents, including the value shifted in at the latest edge.
- R4: While `load_en` is low, the latched view keeps the value it had at the last edge where `load_en` was high, however many bits are shifted meanwhile.
- R5: `load_en`, `show_en` and `keep_pol` have no effect on the shift register or on `sdo`.
- R6: With `show_en`=0 and `keep_pol`=0, every bit of `drv_out` is 1, whatever the latched view holds.
- R7: With `show_en`=0 and `keep_pol`=1, every bit of `drv_out` is 0, whatever the latched view holds.
- R8: With `show_en`=1 and `keep_pol`=0, each `drv_out` bit is the inverse of its latched bit.
- R9: With `show_en`=1 and `keep_pol`=1, each `drv_out` bit equals its latched bit. With `REVERSE`=0, `drv_out[c]` (channel c+1) is fed from stage c+1; with `REVERSE`=1 it is fed from stage N-c.
- R10: A rising edge with `rst_n` low clears all shift stages and the held latch copy to 0, so afterwards `sdo` is 0 and in pass mode `drv_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sdi | input | 1 | Serial data into stage 1 |
| load_en | input | 1 | High: latch follows shift register; low: latch holds |
| show_en | input | 1 | Low: outputs forced to a constant level |
| keep_pol | input | 1 | Selects forced level or true/inverted polarity |
| drv_out | output | N | Conditioned parallel channel outputs, bit c is channel c+1 |
| sdo | output | 1 | Serial data out from stage N for chaining |

## Verification
The hardest situation to reach is a held latch whose contents differ from a shift register that has since been refilled, observed under each of the four output modes. The stimulus loads a random pattern with load-enable high, drops load-enable, then shifts many fresh random bits while cycling the mode inputs, so the outputs can only match the model if the held copy was kept. A second instance built with the reversed channel order is driven in lock-step to show that the stage-to-channel mapping flips and nothing else changes. A single marked bit pushed into a cleared chain measures the serial latency directly.

// File: rtl/sld_pkg.sv
// Package: shared types and helpers for the serial-load latched driver.
// Assumes: nothing beyond standard SystemVerilog.
package sld_pkg;

    // Output conditioning mode decoded from the two control inputs.
    typedef enum logic [1:0] {
        MODE_ALL_HIGH = 2'b00,
        MODE_ALL_LOW  = 2'b01,
        MODE_INVERT   = 2'b10,
        MODE_PASS     = 2'b11
    } out_mode_e;

    // Decode show_en / keep_pol into an output mode.
    function automatic out_mode_e decode_mode(input logic show_en, input logic keep_pol);
        out_mode_e m;
        case ({show_en, keep_pol})
            2'b00:   m = MODE_ALL_HIGH;
            2'b01:   m = MODE_ALL_LOW;
            2'b10:   m = MODE_INVERT;
            default: m = MODE_PASS;
        endcase
        return m;
    endfunction

    // Zero-based stage index that feeds a zero-based channel index.
    function automatic int stage_of_channel(input int ch, input int n, input bit rev);
        return rev ? (n - 1 - ch) : ch;
    endfunction

endpackage

// File: rtl/sld_shift_chain.sv
// Module: N-stage serial shift register.
// Bit k of sr_q is stage k+1; stage 1 takes sdi. sr_next is the value the
// register takes at the coming edge (used by the latch stage).
// Assumes: synchronous active-low reset; no other control affects shifting.
module sld_shift_chain #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    output logic [N-1:0] sr_q,
    output logic [N-1:0] sr_next
);

    // Next-state: move every stage up by one and insert sdi at stage 1.
    always_comb begin
        sr_next = {sr_q[N-2:0], sdi};
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_next;
        end
    end

    // R1
    stage_one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q[0] == $past(sdi)));

    // R1
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sr_q[N-1:1] == $past(sr_q[N-2:0])));

    // R10
    chain_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sr_q == '0));

endmodule

// File: rtl/sld_output_hold.sv
// Module: latch stage between shift register and output conditioning.
// A clocked copy captures the post-shift value on each edge with load_en
// high; a bypass shows the live shift register while load_en is high, so a
// rise of load_en between edges is visible at once.
// Assumes: load_en is synchronous to clk at the edges where it matters.
module sld_output_hold #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [N-1:0] sr_q,
    input  logic [N-1:0] sr_next,
    output logic [N-1:0] view
);

    logic [N-1:0] hold_q;

    // Captured copy: load the post-shift pattern while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_en) begin
            hold_q <= sr_next;
        end
    end

    // Latched view: transparent while open, held copy while closed.
    always_comb begin
        view = load_en ? sr_q : hold_q;
    end

    // R3
    open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (hold_q == sr_q));

    // R4
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (hold_q == $past(hold_q)));

    // R10
    hold_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (hold_q == '0));

endmodule

// File: rtl/sld_channel_map.sv
// Module: routes latched stages onto output channels.
// REVERSE=0: channel c from stage c; REVERSE=1: channel c from stage N-1-c
// (zero-based). Pure wiring.
// Assumes: N >= 1.
module sld_channel_map #(
    parameter int N       = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic [N-1:0] view,
    output logic [N-1:0] mapped
);

    // One routing wire per channel, source chosen at elaboration.
    for (genvar ch = 0; ch < N; ch++) begin : g_route
        localparam int SRC = sld_pkg::stage_of_channel(ch, N, REVERSE);
        assign mapped[ch] = view[SRC];
    end

endmodule

// File: rtl/sld_out_condition.sv
// Module: blanking / polarity conditioning of every channel.
// Assumes: show_en and keep_pol are static levels; purely combinational.
module sld_out_condition #(
    parameter int N = 32
) (
    input  logic         show_en,
    input  logic         keep_pol,
    input  logic [N-1:0] mapped,
    output logic [N-1:0] drv_out
);

    import sld_pkg::*;

    out_mode_e mode;

    // Decode the shared mode once for all channels.
    always_comb begin
        mode = decode_mode(show_en, keep_pol);
    end

    // Per-channel cell: force, invert or pass the latched bit.
    for (genvar ch = 0; ch < N; ch++) begin : g_cell
        always_comb begin
            case (mode)
                MODE_ALL_HIGH: drv_out[ch] = 1'b1;
                MODE_ALL_LOW:  drv_out[ch] = 1'b0;
                MODE_INVERT:   drv_out[ch] = ~mapped[ch];
                default:       drv_out[ch] = mapped[ch];
            endcase
        end
    end

endmodule

// File: rtl/serial_latched_driver.sv
// Module: top of the serial-load latched output driver.
// Serial data shifts through N stages; a latch stage passes or holds the
// pattern; channel mapping and blanking/polarity conditioning drive the
// parallel outputs; sdo exposes the last stage for chaining.
// Assumes: single clock, synchronous active-low reset, N >= 2.
module serial_latched_driver #(
    parameter int N       = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         load_en,
    input  logic         show_en,
    input  logic         keep_pol,
    output logic [N-1:0] drv_out,
    output logic         sdo
);

    localparam int LAST = N - 1;

    logic [N-1:0] sr_q;
    logic [N-1:0] sr_next;
    logic [N-1:0] view;
    logic [N-1:0] mapped;

    sld_shift_chain #(.N(N)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdi     (sdi),
        .sr_q    (sr_q),
        .sr_next (sr_next)
    );

    sld_output_hold #(.N(N)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .sr_q    (sr_q),
        .sr_next (sr_next),
        .view    (view)
    );

    sld_channel_map #(.N(N), .REVERSE(REVERSE)) u_map (
        .view   (view),
        .mapped (mapped)
    );

    sld_out_condition #(.N(N)) u_cond (
        .show_en  (show_en),
        .keep_pol (keep_pol),
        .mapped   (mapped),
        .drv_out  (drv_out)
    );

    // Chain output: last stage straight out.
    assign sdo = sr_q[LAST];

    // R2
    chain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sdo == $past(sr_q[LAST-1])));

    // R6
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_en && !keep_pol) |-> (drv_out == '1));

    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_en && keep_pol) |-> (drv_out == '0));

endmodule

// File: tb/serial_latched_driver_test.sv
module serial_latched_driver_test;

    localparam int N  = 32;
    localparam int TP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdi = 1'b0;
    logic         load_en = 1'b0;
    logic         show_en = 1'b1;
    logic         keep_pol = 1'b1;
    logic [N-1:0] drv_out, drv_out_rev;
    logic         sdo, sdo_rev;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit model_ok = 0;

    // Reference model state: newest bit first; stage k is hist[k-1].
    bit hist[$];
    bit hold_m[N];

    always #(TP/2) clk = ~clk;

    serial_latched_driver #(.N(N), .REVERSE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .load_en(load_en),
        .show_en(show_en), .keep_pol(keep_pol), .drv_out(drv_out), .sdo(sdo));

    serial_latched_driver #(.N(N), .REVERSE(1'b1)) uut_rev (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .load_en(load_en),
        .show_en(show_en), .keep_pol(keep_pol), .drv_out(drv_out_rev), .sdo(sdo_rev));

    function automatic bit stage_m(int k);
        return (k <= hist.size()) ? hist[k-1] : 1'b0;
    endfunction

    function automatic logic [N-1:0] expect_out(bit rev);
        logic [N-1:0] r;
        for (int c = 1; c <= N; c++) begin
            int s = rev ? (N + 1 - c) : c;
            bit v = load_en ? stage_m(s) : hold_m[s-1];
            case ({show_en, keep_pol})
                2'b00: r[c-1] = 1'b1;
                2'b01: r[c-1] = 1'b0;
                2'b10: r[c-1] = ~v;
                default: r[c-1] = v;
            endcase
        end
        return r;
    endfunction

    function automatic string mode_tag();
        case ({show_en, keep_pol})
            2'b00: return "R6";
            2'b01: return "R7";
            2'b10: return "R8";
            default: return "R1 R9";
        endcase
    endfunction

    task automatic check_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model for the current inputs.
    task automatic compare_all();
        string lt;
        if (!model_ok) return;
        lt = load_en ? " R3" : " R4";
        check_vec({mode_tag(), lt}, drv_out, expect_out(1'b0));
        check_vec({mode_tag(), lt, " R9 reversed"}, drv_out_rev, expect_out(1'b1));
        check_bit("R2 R5 sdo", sdo, stage_m(N));
        check_bit("R2 R5 sdo reversed", sdo_rev, stage_m(N));
    endtask

    // One cycle: drive at negedge, check, advance model at posedge, return at negedge.
    task automatic step(logic d, logic le, logic en, logic pol);
        sdi = d; load_en = le; show_en = en; keep_pol = pol;
        #1 compare_all();
        @(posedge clk);
        if (!rst_n) begin
            hist.delete();
            foreach (hold_m[i]) hold_m[i] = 1'b0;
            model_ok = 1;
        end else if (model_ok) begin
            hist.push_front(d);
            if (hist.size() > N) void'(hist.pop_back());
            if (le) for (int k = 1; k <= N; k++) hold_m[k-1] = stage_m(k);
        end
        @(negedge clk);
    endtask

    task automatic do_reset(int cycles);
        rst_n = 1'b0;
        repeat (cycles) step($urandom_range(0, 1), 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        #(TP * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, seen;
        @(negedge clk);
        do_reset(3);
        // R10: cleared state in pass mode, latch closed.
        sdi = 0; load_en = 0; show_en = 1; keep_pol = 1;
        #1;
        check_vec("R10 outputs after reset", drv_out, '0);
        check_bit("R10 sdo after reset", sdo, 1'b0);
        @(negedge clk);

        // Open latch, pass mode, random data (R1 R3 R9).
        repeat (40) step($urandom_range(0, 1), 1'b1, 1'b1, 1'b1);

        // Close latch, keep shifting under every mode (R4 R5 R6 R7 R8).
        for (int m = 0; m < 4; m++)
            repeat (45) step($urandom_range(0, 1), 1'b0, m[1], m[0]);

        // Reload, then close again with inverted view.
        repeat (34) step($urandom_range(0, 1), 1'b1, 1'b1, 1'b0);
        repeat (40) step($urandom_range(0, 1), 1'b0, 1'b1, 1'b0);

        // Random mix of everything with occasional latch pulses.
        repeat (600) step($urandom_range(0, 1), ($urandom_range(0, 7) == 0),
                          $urandom_range(0, 1), $urandom_range(0, 1));

        // Mid-run reset then refill (R10).
        do_reset(2);
        sdi = 0; load_en = 0; show_en = 1; keep_pol = 1;
        #1;
        check_vec("R10 outputs after second reset", drv_out, '0);
        check_vec("R10 reversed outputs after second reset", drv_out_rev, '0);
        @(negedge clk);

        // Serial latency: one marked bit into a cleared chain (R2).
        step(1'b1, 1'b0, 1'b1, 1'b1);
        n = 1; seen = 0;
        repeat (40) begin
            if (sdo === 1'b1 && seen == 0) seen = n;
            step(1'b0, 1'b0, 1'b1, 1'b1);
            n++;
        end
        total++;
        if (seen != N) begin
            bad++;
            $display("FAIL R2 latency: got %0d expected %0d", seen, N);
        end
        // R4: latch stayed closed, outputs still zero after the bit passed.
        check_vec("R4 closed latch after latency run", drv_out, '0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule